// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block owns the 8-bit stack pointer of a small processor core and moves stack bytes through one port of a 256-byte internal RAM. It handles five kinds of stack traffic: pushing a byte, popping a byte (to an ordinary destination or into the stack pointer itself), saving a return address while branching to a call target, and restoring a program counter on a return or on a return from an interrupt. The instruction decoder presents one operation together with its operands. The RAM sits outside the block and has a synchronous read: data appears on `ram_rdata` in the cycle after a read strobe.

Each RAM access takes one cycle, so a push or pop occupies the block for two or three cycles and a call or return for three or four. `busy` is high for the whole sequence. While it is high, new operations are dropped. Popped bytes appear with a one-cycle valid flag. A new program counter appears with a one-cycle load flag. A return from interrupt also raises a release pulse for the interrupt controller. The status word is not touched.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 07h, `busy` is low and neither RAM strobe is active.
- R2: Operation codes on `op` are sampled while `op_valid` is high and `busy` is low: 1 = push, 2 = pop, 3 = pop into SP, 4 = call, 5 = return, 6 = return from interrupt. Codes 0 and 7 do nothing.
- R3: A push first raises SP by one and then writes `push_data` at the new SP. Starting from SP = 4Fh, pushing 11h and then 12h leaves SP = 51h, with 11h at 50h and 12h at 51h.
- R4: A pop reads the RAM at SP and then lowers SP by one. The byte read is shown on `pop_data` while `pop_valid` is high for one cycle.
- R5: A pop into SP lowers SP first. SP shows the decremented value in the `pop_valid` cycle, and the popped byte then overwrites SP.
- R6: A call writes the return address low byte at SP+1 and then the high byte at SP+2, which leaves SP raised by two. It then pulses `pc_load` with `pc_out` equal to the call target. With return address 0233h and SP = 07h, the call leaves 33h at 08h, 02h at 09h and SP = 09h.
- R7: A return reads the high byte at SP and the low byte at SP-1, which leaves SP lowered by two. It then pulses `pc_load` with `pc_out` equal to that address, and `irq_release` stays low.
- R8: A return from interrupt behaves exactly like a return. It also raises `irq_release` for one cycle, in the same cycle as `pc_load`.
- R9: `busy` stays high from the cycle after an operation is accepted until the sequence ends. Operations presented while `busy` is high have no effect on SP or RAM.
- R10: SP wraps modulo 256 in both directions.
- R11: `ram_rd` and `ram_wr` are never high in the same cycle, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op | input | 3 | Operation code |
| push_data | input | 8 | Byte to push |
| ret_pc | input | 16 | Return address for a call, already advanced past the call |
| call_target | input | 16 | Branch target for a call |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_rd` |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | `pop_data` is valid |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | `pc_out` is valid |
| irq_release | output | 1 | Interrupt controller may accept new requests |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check the cycle-level rules on every cycle:
- the pre-increment on a push and the decrement after every stack read, including modulo-256 wrap;
- that the two strobes are exclusive and confined to busy cycles;
- that the release pulse only comes with a PC load.

The byte order of the return address in RAM, the values returned by pop and return, and the ordering of the SP overwrite in a pop into SP can only be shown by the bench's scenarios. So can the dropping of operations offered mid-sequence, since these need a RAM model and knowledge of the operand values.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DW = 8,
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op,
  input  logic [DW-1:0]     push_data,
  input  logic [2*DW-1:0]   ret_pc,
  input  logic [2*DW-1:0]   call_target,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [DW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     pop_data,
  output logic              pop_valid,
  output logic [2*DW-1:0]   pc_out,
  output logic              pc_load,
  output logic              irq_release,
  output logic [DW-1:0]     sp,
  output logic              busy
);
  localparam int PCW = 2 * DW;
  localparam logic [2:0] OP_PUSH = 3'd1, OP_POP = 3'd2, OP_POPSP = 3'd3,
                         OP_CALL = 3'd4, OP_RET = 3'd5, OP_RETI = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH, S_POPR, S_POPD, S_CALLL, S_CALLH, S_RETH, S_RETL, S_RETD
  } state_t;

  state_t          state;
  logic [DW-1:0]   byte_q, hi_q;
  logic [PCW-1:0]  ret_q, tgt_q;
  logic            to_sp, is_reti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sp      <= DW'(SP_RESET);
      byte_q  <= '0;
      hi_q    <= '0;
      ret_q   <= '0;
      tgt_q   <= '0;
      to_sp   <= 1'b0;
      is_reti <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (op_valid) begin
          case (op)
            OP_PUSH: begin
              sp     <= sp + 1'b1;
              byte_q <= push_data;
              state  <= S_PUSH;
            end
            OP_POP, OP_POPSP: begin
              to_sp <= (op == OP_POPSP);
              state <= S_POPR;
            end
            OP_CALL: begin
              sp    <= sp + 1'b1;
              ret_q <= ret_pc;
              tgt_q <= call_target;
              state <= S_CALLL;
            end
            OP_RET, OP_RETI: begin
              is_reti <= (op == OP_RETI);
              state   <= S_RETH;
            end
            default: state <= S_IDLE;
          endcase
        end
        S_POPR: begin
          sp    <= sp - 1'b1;
          state <= S_POPD;
        end
        S_POPD: begin
          if (to_sp) sp <= ram_rdata;
          state <= S_IDLE;
        end
        S_CALLL: begin
          sp    <= sp + 1'b1;
          state <= S_CALLH;
        end
        S_RETH: begin
          sp    <= sp - 1'b1;
          state <= S_RETL;
        end
        S_RETL: begin
          sp    <= sp - 1'b1;
          hi_q  <= ram_rdata;
          state <= S_RETD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign ram_wr      = (state == S_PUSH) || (state == S_CALLL) || (state == S_CALLH);
  assign ram_rd      = (state == S_POPR) || (state == S_RETH) || (state == S_RETL);
  assign ram_addr    = sp;
  assign ram_wdata   = (state == S_PUSH)  ? byte_q :
                       (state == S_CALLL) ? ret_q[DW-1:0] : ret_q[PCW-1:DW];
  assign pop_valid   = (state == S_POPD);
  assign pop_data    = ram_rdata;
  assign pc_load     = (state == S_CALLH) || (state == S_RETD);
  assign pc_out      = (state == S_CALLH) ? tgt_q : {hi_q, ram_rdata};
  assign irq_release = (state == S_RETD) && is_reti;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op,
  input logic          ram_rd,
  input logic          ram_wr,
  input logic          pc_load,
  input logic          irq_release,
  input logic [DW-1:0] sp,
  input logic          busy
);
  a_r3_push_preinc: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_valid && op == 3'd1) |=> (ram_wr && sp == DW'($past(sp) + 1'b1)));

  a_r4_read_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> (sp == DW'($past(sp) - 1'b1)));

  a_r8_release_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |-> pc_load);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd, ram_wr}));

  a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_rd && !ram_wr));
endmodule

bind stack_seq stack_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
  .ram_rd(ram_rd), .ram_wr(ram_wr), .pc_load(pc_load),
  .irq_release(irq_release), .sp(sp), .busy(busy)
);

// File: tb/stack_seq_tb.sv
module stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [7:0]  push_data = 8'h00;
  logic [15:0] ret_pc = 16'h0000;
  logic [15:0] call_target = 16'h0000;
  logic        ram_rd, ram_wr, pop_valid, pc_load, irq_release, busy;
  logic [7:0]  ram_addr, ram_wdata, pop_data, sp;
  logic [7:0]  ram_rdata = 8'h00;
  logic [15:0] pc_out;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] mem [256];
  logic       poke_en = 1'b0;
  logic [7:0] poke_addr = 8'h00, poke_val = 8'h00;

  logic [7:0]  last_pop = 8'h00, sp_at_pop = 8'h00;
  logic [15:0] last_pc = 16'h0000;
  logic        last_rel = 1'b0;
  int          rel_cnt = 0, strobe_err = 0;

  always #4 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .push_data(push_data), .ret_pc(ret_pc), .call_target(call_target),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pop_data(pop_data),
    .pop_valid(pop_valid), .pc_out(pc_out), .pc_load(pc_load),
    .irq_release(irq_release), .sp(sp), .busy(busy)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_val;
    else if (ram_wr) mem[ram_addr] <= ram_wdata;
    if (ram_rd) ram_rdata <= mem[ram_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_valid) begin last_pop = pop_data; sp_at_pop = sp; end
      if (pc_load) begin last_pc = pc_out; last_rel = irq_release; end
      if (irq_release) rel_cnt++;
      if ((ram_rd && ram_wr) || (!busy && (ram_rd || ram_wr))) strobe_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_val = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] code);
    @(negedge clk); op_valid = 1'b1; op = code;
    @(negedge clk); op_valid = 1'b0; op = 3'd0;
    while (busy) @(negedge clk);
  endtask

  task automatic set_sp(input logic [7:0] v);
    poke(sp, v);
    issue(3'd3);
  endtask

  task automatic t_reset;
    chk(sp == 8'h07, "R1 sp", sp, 8'h07);
    chk(!busy && !ram_rd && !ram_wr, "R1 idle", {busy, ram_rd, ram_wr}, 0);
  endtask

  task automatic t_pop_to_sp;
    poke(8'h07, 8'h4F);
    issue(3'd3);
    chk(sp_at_pop == 8'h06, "R5 dec first", sp_at_pop, 8'h06);
    chk(sp == 8'h4F, "R5 overwrite", sp, 8'h4F);
  endtask

  task automatic t_push;
    push_data = 8'h11; issue(3'd1);
    push_data = 8'h12; issue(3'd1);
    chk(sp == 8'h51, "R3 sp", sp, 8'h51);
    chk(mem[8'h50] == 8'h11, "R3 mem50", mem[8'h50], 8'h11);
    chk(mem[8'h51] == 8'h12, "R3 mem51", mem[8'h51], 8'h12);
  endtask

  task automatic t_pop;
    issue(3'd2);
    chk(last_pop == 8'h12 && sp == 8'h50, "R4 first pop", {last_pop, sp}, 16'h1250);
    issue(3'd2);
    chk(last_pop == 8'h11 && sp == 8'h4F, "R4 second pop", {last_pop, sp}, 16'h114F);
  endtask

  task automatic t_nop_codes;
    issue(3'd0);
    issue(3'd7);
    chk(sp == 8'h4F, "R2 codes 0 and 7", sp, 8'h4F);
  endtask

  task automatic t_call_ignore;
    set_sp(8'h07);
    poke(8'h0A, 8'h5A);
    ret_pc = 16'h0233; call_target = 16'h1234;
    @(negedge clk); op_valid = 1'b1; op = 3'd4;
    @(negedge clk); op = 3'd1; push_data = 8'hEE;
    chk(busy == 1'b1, "R9 busy", busy, 1);
    @(negedge clk); op_valid = 1'b0; op = 3'd0;
    while (busy) @(negedge clk);
    chk(mem[8'h08] == 8'h33, "R6 low byte", mem[8'h08], 8'h33);
    chk(mem[8'h09] == 8'h02, "R6 high byte", mem[8'h09], 8'h02);
    chk(sp == 8'h09, "R6 sp", sp, 8'h09);
    chk(last_pc == 16'h1234, "R6 target", last_pc, 16'h1234);
    chk(mem[8'h0A] == 8'h5A, "R9 ignored push", mem[8'h0A], 8'h5A);
  endtask

  task automatic t_ret;
    issue(3'd5);
    chk(last_pc == 16'h0233, "R7 pc", last_pc, 16'h0233);
    chk(sp == 8'h07, "R7 sp", sp, 8'h07);
    chk(!last_rel && rel_cnt == 0, "R7 no release", rel_cnt, 0);
  endtask

  task automatic t_reti;
    ret_pc = 16'h0456; call_target = 16'h0003;
    issue(3'd4);
    issue(3'd6);
    chk(last_pc == 16'h0456 && sp == 8'h07, "R8 pc/sp", last_pc, 16'h0456);
    chk(last_rel && rel_cnt == 1, "R8 release", rel_cnt, 1);
  endtask

  task automatic t_wrap;
    set_sp(8'hFF);
    chk(sp == 8'hFF, "R10 setup", sp, 8'hFF);
    push_data = 8'hAA; issue(3'd1);
    chk(sp == 8'h00 && mem[8'h00] == 8'hAA, "R10 up wrap", {sp, mem[8'h00]}, 16'h00AA);
    issue(3'd2);
    chk(sp == 8'hFF && last_pop == 8'hAA, "R10 down wrap", {sp, last_pop}, 16'hFFAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pop_to_sp;
    t_push;
    t_pop;
    t_nop_codes;
    t_call_ignore;
    t_ret;
    t_reti;
    t_wrap;
    chk(strobe_err == 0, "R11 strobes", strobe_err, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule